// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node directory for a group of cores that share memory. For every memory block it owns, it keeps a coherence state and a presence vector with one bit per core. It also holds a small backing store with the block data. Cores send it read misses, write misses and write-backs. It answers with data replies, invalidates, and fetch or fetch-and-invalidate requests to a current owner. It updates its state and backing data as the transitions require.

Requests arrive on one request port, and the ready signal of that port stalls them. The data that an owner returns after a fetch arrives on a separate response port, so a stalled request can never block the reply it waits for. Outgoing messages leave on a single registered port, one message per cycle. A multi-target invalidate is sent as a sequence of messages, lowest node first, and the data reply to the writer follows it.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty presence vector, block i of the backing store holds the value i, `req_ready_o` is high and no message is driven.
- R2: A read miss (request type 0) to an uncached block produces, in the cycle after acceptance, one data message (type 0) to the requester carrying the stored value. The block becomes shared with the requester as its only sharer.
- R3: A read miss to a shared block returns the stored value in a data message and adds the requester to the sharers.
- R4: A write miss (request type 1) to an uncached block returns the stored value in a data message, and the requester becomes the exclusive owner.
- R5: A write miss to a shared block sends one invalidate (type 1, data 0) to every sharer except the requester, one per cycle, in ascending node order, starting the cycle after acceptance. A data message to the requester with the stored value follows at once. The requester becomes the sole exclusive owner.
- R6: A read miss to an exclusive block sends a fetch (type 2) to the owner. When the owner's response arrives, its data is written to the backing store and forwarded to the requester in a data message. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (type 3) to the owner. The owner's response data is forwarded to the requester, who becomes the new exclusive owner.
- R8: A write-back (request type 2) from the owner of an exclusive block writes its data to the backing store, makes the block uncached and produces no message.
- R9: A write-back from a node that is not the exclusive owner produces no message and leaves the state and the stored data unchanged.
- R10: While a fetch is outstanding, `req_ready_o` is low and no request is accepted. A response from the wrong node or for the wrong block is ignored.
- R11: `req_ready_o` is low from the acceptance of a write miss that needs invalidates until its data reply has been sent. It stays high after a write miss that needs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node_i | input | NODE_W | Requesting node |
| req_addr_i | input | ADDR_W | Block index |
| req_data_i | input | DATA_W | Write-back data |
| resp_valid_i | input | 1 | Owner data response present |
| resp_node_i | input | NODE_W | Responding node |
| resp_addr_i | input | ADDR_W | Block index of the response |
| resp_data_i | input | DATA_W | Data returned by the owner |
| msg_valid_o | output | 1 | Outgoing message valid for one cycle |
| msg_type_o | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node_o | output | NODE_W | Destination node |
| msg_addr_o | output | ADDR_W | Block index |
| msg_data_o | output | DATA_W | Payload (0 for invalidates and fetches) |

## Verification
The write-miss path is swept over every non-empty sharer set of four nodes, with each node in turn as the writer. A writer that is already a sharer shows that it is never invalidated, and sets of different sizes show the ascending order and the point where the reply follows. Every ordered owner/requester pair runs through the exclusive-block read and write paths, with foreign responses and blocked requests pushed in during the fetch. Later transactions reveal the resulting state: the presence of a fetch, the invalidate targets and the returned data tell an uncached, shared or exclusive block apart, and show whether memory was written back.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {BLK_U = 2'd0, BLK_S = 2'd1, BLK_E = 2'd2} blk_state_e;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2} req_type_e;
  typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FETCH_INV = 2'd3} msg_type_e;
  typedef enum logic [1:0] {CT_IDLE, CT_INV, CT_REPLY, CT_WAIT} ctl_state_e;
endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  // remaining bits once the lowest one is served
  assign rest_o = vec_i & (vec_i - N'(1));
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int NUM_NODES  = 4,
  parameter int DATA_W     = 16,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output blk_state_e           rd_state_o,
  output logic [NUM_NODES-1:0] rd_sharers_o,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 dir_we_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  blk_state_e           wr_state_i,
  input  logic [NUM_NODES-1:0] wr_sharers_i,
  input  logic                 mem_we_i,
  input  logic [DATA_W-1:0]    mem_wdata_i
);
  blk_state_e           state_arr [NUM_BLOCKS];
  logic [NUM_NODES-1:0] sh_arr    [NUM_BLOCKS];
  logic [DATA_W-1:0]    mem_arr   [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    blk_state_e           st_q;
    logic [NUM_NODES-1:0] sh_q;
    logic [DATA_W-1:0]    mem_q;
    logic                 hit;
    assign hit = (wr_addr_i == ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= BLK_U;
        sh_q  <= '0;
        mem_q <= DATA_W'(b);
      end else begin
        if (dir_we_i && hit) begin
          st_q <= wr_state_i;
          sh_q <= wr_sharers_i;
        end
        if (mem_we_i && hit) mem_q <= mem_wdata_i;
      end
    end

    assign state_arr[b] = st_q;
    assign sh_arr[b]    = sh_q;
    assign mem_arr[b]   = mem_q;
  end

  assign rd_state_o   = state_arr[rd_addr_i];
  assign rd_sharers_o = sh_arr[rd_addr_i];
  assign rd_data_o    = mem_arr[rd_addr_i];
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_NODES  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              resp_valid_i,
  input  logic [NODE_W-1:0] resp_node_i,
  input  logic [ADDR_W-1:0] resp_addr_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [NODE_W-1:0] msg_node_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  localparam logic [NUM_NODES-1:0] ONE = NUM_NODES'(1);

  ctl_state_e           ctl_q, ctl_d;
  logic [ADDR_W-1:0]    pend_addr_q, pend_addr_d;
  logic [NODE_W-1:0]    pend_node_q, pend_node_d;
  logic [NODE_W-1:0]    owner_q, owner_d;
  logic                 pend_wr_q, pend_wr_d;
  logic [NUM_NODES-1:0] inv_mask_q, inv_mask_d;
  logic [DATA_W-1:0]    reply_data_q, reply_data_d;

  blk_state_e           cur_state;
  logic [NUM_NODES-1:0] cur_sh, req_bit, inv_first;
  logic [DATA_W-1:0]    cur_data;

  logic                 dir_we, mem_we;
  logic [ADDR_W-1:0]    wr_addr;
  blk_state_e           wr_state;
  logic [NUM_NODES-1:0] wr_sh;
  logic [DATA_W-1:0]    mem_wdata;

  logic              out_v;
  msg_type_e         out_t;
  logic [NODE_W-1:0] out_n;
  logic [ADDR_W-1:0] out_a;
  logic [DATA_W-1:0] out_d;

  logic              msg_valid_q;
  msg_type_e         msg_type_q;
  logic [NODE_W-1:0] msg_node_q;
  logic [ADDR_W-1:0] msg_addr_q;
  logic [DATA_W-1:0] msg_data_q;

  logic [NODE_W-1:0]    own_idx, inv0_idx, inv1_idx;
  logic [NUM_NODES-1:0] own_rest, inv0_rest, inv1_rest;

  dir_store #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_NODES(NUM_NODES), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(req_addr_i), .rd_state_o(cur_state), .rd_sharers_o(cur_sh), .rd_data_o(cur_data),
    .dir_we_i(dir_we), .wr_addr_i(wr_addr), .wr_state_i(wr_state), .wr_sharers_i(wr_sh),
    .mem_we_i(mem_we), .mem_wdata_i(mem_wdata)
  );

  assign req_bit   = ONE << req_node_i;
  assign inv_first = cur_sh & ~req_bit;

  dir_pick #(.N(NUM_NODES)) u_pick_own  (.vec_i(cur_sh),     .idx_o(own_idx),  .rest_o(own_rest));
  dir_pick #(.N(NUM_NODES)) u_pick_inv0 (.vec_i(inv_first),  .idx_o(inv0_idx), .rest_o(inv0_rest));
  dir_pick #(.N(NUM_NODES)) u_pick_inv1 (.vec_i(inv_mask_q), .idx_o(inv1_idx), .rest_o(inv1_rest));

  assign req_ready_o = (ctl_q == CT_IDLE);

  always_comb begin
    ctl_d        = ctl_q;
    pend_addr_d  = pend_addr_q;
    pend_node_d  = pend_node_q;
    owner_d      = owner_q;
    pend_wr_d    = pend_wr_q;
    inv_mask_d   = inv_mask_q;
    reply_data_d = reply_data_q;
    dir_we    = 1'b0;
    mem_we    = 1'b0;
    wr_addr   = req_addr_i;
    wr_state  = BLK_U;
    wr_sh     = '0;
    mem_wdata = req_data_i;
    out_v = 1'b0;
    out_t = MSG_DATA;
    out_n = req_node_i;
    out_a = req_addr_i;
    out_d = cur_data;
    unique case (ctl_q)
      CT_IDLE: if (req_valid_i) begin
        pend_addr_d = req_addr_i;
        pend_node_d = req_node_i;
        case (req_type_i)
          REQ_RD, REQ_WR: begin
            out_v = 1'b1;
            if (cur_state == BLK_E) begin
              out_t     = (req_type_i == REQ_WR) ? MSG_FETCH_INV : MSG_FETCH;
              out_n     = own_idx;
              out_d     = '0;
              owner_d   = own_idx;
              pend_wr_d = (req_type_i == REQ_WR);
              ctl_d     = CT_WAIT;
            end else if (req_type_i == REQ_RD) begin
              dir_we   = 1'b1;
              wr_state = BLK_S;
              wr_sh    = cur_sh | req_bit;
            end else begin
              dir_we   = 1'b1;
              wr_state = BLK_E;
              wr_sh    = req_bit;
              if (inv_first != '0) begin
                out_t        = MSG_INV;
                out_n        = inv0_idx;
                out_d        = '0;
                inv_mask_d   = inv0_rest;
                reply_data_d = cur_data;
                ctl_d        = (inv0_rest != '0) ? CT_INV : CT_REPLY;
              end
            end
          end
          REQ_WB: if (cur_state == BLK_E && (cur_sh & req_bit) != '0) begin
            dir_we = 1'b1;
            mem_we = 1'b1;
          end
          default: ;
        endcase
      end
      CT_INV: begin
        out_v      = 1'b1;
        out_t      = MSG_INV;
        out_n      = inv1_idx;
        out_a      = pend_addr_q;
        out_d      = '0;
        inv_mask_d = inv1_rest;
        if (inv1_rest == '0) ctl_d = CT_REPLY;
      end
      CT_REPLY: begin
        out_v = 1'b1;
        out_n = pend_node_q;
        out_a = pend_addr_q;
        out_d = reply_data_q;
        ctl_d = CT_IDLE;
      end
      CT_WAIT: if (resp_valid_i && resp_node_i == owner_q && resp_addr_i == pend_addr_q) begin
        out_v   = 1'b1;
        out_n   = pend_node_q;
        out_a   = pend_addr_q;
        out_d   = resp_data_i;
        dir_we  = 1'b1;
        wr_addr = pend_addr_q;
        if (pend_wr_q) begin
          wr_state = BLK_E;
          wr_sh    = ONE << pend_node_q;
        end else begin
          wr_state  = BLK_S;
          wr_sh     = (ONE << owner_q) | (ONE << pend_node_q);
          mem_we    = 1'b1;
          mem_wdata = resp_data_i;
        end
        ctl_d = CT_IDLE;
      end
      default: ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q        <= CT_IDLE;
      pend_addr_q  <= '0;
      pend_node_q  <= '0;
      owner_q      <= '0;
      pend_wr_q    <= 1'b0;
      inv_mask_q   <= '0;
      reply_data_q <= '0;
      msg_valid_q  <= 1'b0;
      msg_type_q   <= MSG_DATA;
      msg_node_q   <= '0;
      msg_addr_q   <= '0;
      msg_data_q   <= '0;
    end else begin
      ctl_q        <= ctl_d;
      pend_addr_q  <= pend_addr_d;
      pend_node_q  <= pend_node_d;
      owner_q      <= owner_d;
      pend_wr_q    <= pend_wr_d;
      inv_mask_q   <= inv_mask_d;
      reply_data_q <= reply_data_d;
      msg_valid_q  <= out_v;
      msg_type_q   <= out_t;
      msg_node_q   <= out_n;
      msg_addr_q   <= out_a;
      msg_data_q   <= out_d;
    end
  end

  assign msg_valid_o = msg_valid_q;
  assign msg_type_o  = msg_type_q;
  assign msg_node_o  = msg_node_q;
  assign msg_addr_o  = msg_addr_q;
  assign msg_data_o  = msg_data_q;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_type_i,
  input logic              msg_valid_o,
  input logic [1:0]        msg_type_o,
  input logic [NODE_W-1:0] msg_node_o,
  input logic [NODE_W-1:0] pend_node_q
);
  logic inv_now;
  assign inv_now = msg_valid_o && (msg_type_o == 2'd1);

  AST_INV_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_now |-> !req_ready_o); // R11
  AST_FETCH_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o[1]) |-> !req_ready_o); // R10
  AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_now |-> (msg_node_o != pend_node_q)); // R5
  AST_INV_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_now && $past(inv_now)) |-> (msg_node_o > $past(msg_node_o))); // R5
  AST_INV_FOLLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_now |=> msg_valid_o); // R5
  AST_WB_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_type_i == 2'd2) |=> !msg_valid_o); // R8
endmodule

bind dir_ctrl dir_ctrl_chk #(.NODE_W(NODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_type_i(req_type_i), .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o),
  .msg_node_o(msg_node_o), .pend_node_q(pend_node_q)
);

// File: tb/dir_ctrl_tb.sv
module dir_ctrl_tb_top;
  localparam int NN = 4, NB = 8, DW = 16, NW = 2, AW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, resp_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [NW-1:0] req_node = '0, resp_node = '0;
  logic [AW-1:0] req_addr = '0, resp_addr = '0;
  logic [DW-1:0] req_data = '0, resp_data = '0;
  logic req_ready_o, msg_valid_o;
  logic [1:0] msg_type_o;
  logic [NW-1:0] msg_node_o;
  logic [AW-1:0] msg_addr_o;
  logic [DW-1:0] msg_data_o;

  always #5 clk = ~clk;

  dir_ctrl #(.NUM_NODES(NN), .NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_type_i(req_type), .req_node_i(req_node), .req_addr_i(req_addr), .req_data_i(req_data),
    .resp_valid_i(resp_valid), .resp_node_i(resp_node), .resp_addr_i(resp_addr), .resp_data_i(resp_data),
    .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o), .msg_node_o(msg_node_o),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
  );

  int checks = 0, failures = 0, log_n = 0, rd_p = 0;
  int lg [0:4095];
  int exp_mem [NB];

  always @(posedge clk) begin
    #2;
    if (rst_ni && msg_valid_o && log_n < 4096) begin
      lg[log_n] = (int'(msg_type_o) << 24) | (int'(msg_node_o) << 20) | (int'(msg_addr_o) << 16) | int'(msg_data_o);
      log_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_msg(int t, int n, int a, int d, string req);
    int e;
    e = (t << 24) | (n << 20) | (a << 16) | d;
    if (rd_p >= log_n) chk(1'b0, req, "missing message", 0, e);
    else begin
      chk(lg[rd_p] == e, req, "message", lg[rd_p], e);
      rd_p++;
    end
  endtask

  task automatic exp_none(string req);
    chk(rd_p == log_n, req, "unexpected message count", log_n, rd_p);
    rd_p = log_n;
  endtask

  task automatic send(int t, int n, int a, int d);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_node = NW'(n); req_addr = AW'(a); req_data = DW'(d);
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic resp(int n, int a, int d);
    @(negedge clk);
    resp_valid = 1'b1; resp_node = NW'(n); resp_addr = AW'(a); resp_data = DW'(d);
    @(posedge clk); #1;
    resp_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) exp_mem[i] = i;
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", req_ready_o, 1);
    chk(msg_valid_o == 1'b0, "R1", "msg valid in reset", msg_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready_o == 1'b1 && msg_valid_o == 1'b0, "R1", "idle after reset", {req_ready_o, msg_valid_o}, 2);

    // shared-write sweep: every sharer set, every writer
    for (int mask = 1; mask < 16; mask++) begin
      for (int w = 0; w < NN; w++) begin
        int a, ninv, nd;
        bit first;
        a = (mask * 4 + w) % NB;
        first = 1'b1;
        ninv = 0;
        for (int n = 0; n < NN; n++) if (mask[n]) begin
          send(0, n, a, 0);
          wait_idle();
          exp_msg(0, n, a, exp_mem[a], first ? "R2" : "R3");
          first = 1'b0;
          if (n != w) ninv++;
        end
        send(1, w, a, 0);
        @(negedge clk);
        chk(req_ready_o == (ninv == 0), "R11", "ready after write miss", req_ready_o, ninv == 0);
        wait_idle();
        for (int n = 0; n < NN; n++) if (mask[n] && n != w) exp_msg(1, n, a, 0, "R5");
        exp_msg(0, w, a, exp_mem[a], (mask == (1 << w)) ? "R4" : "R5");
        exp_none("R5");
        nd = 16'h1000 + mask * 16 + w;
        send(2, w, a, nd);
        wait_idle();
        exp_none("R8");
        exp_mem[a] = nd;
      end
    end

    // exclusive-block paths for every owner/requester pair
    for (int o = 0; o < NN; o++) begin
      for (int r = 0; r < NN; r++) if (r != o) begin
        int a, d1, d2, d3, d4;
        a = (o * 4 + r) % NB;
        d1 = 16'h2000 + o * 16 + r; d2 = d1 + 16'h1000; d3 = d1 + 16'h2000; d4 = d1 + 16'h3000;
        send(1, o, a, 0);
        wait_idle();
        exp_msg(0, o, a, exp_mem[a], "R4");
        send(0, r, a, 0);
        @(negedge clk);
        chk(req_ready_o == 1'b0, "R10", "ready during fetch", req_ready_o, 0);
        exp_msg(2, o, a, 0, "R6");
        req_valid = 1'b1; req_type = 2'd0; req_node = NW'(r); req_addr = AW'(a);
        resp_valid = 1'b1; resp_node = NW'((o + 1) % NN == r ? (o + 2) % NN : (o + 1) % NN);
        resp_addr = AW'(a); resp_data = 16'hbad0;
        @(negedge clk);
        resp_node = NW'(o); resp_addr = AW'(a + 1);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(req_ready_o == 1'b0, "R10", "ready while stalled", req_ready_o, 0);
        end
        req_valid = 1'b0; resp_valid = 1'b0;
        exp_none("R10");
        resp(o, a, d1);
        wait_idle();
        exp_msg(0, r, a, d1, "R6");
        exp_mem[a] = d1;
        send(1, o, a, 0);
        wait_idle();
        exp_msg(1, r, a, 0, "R6");
        exp_msg(0, o, a, d1, "R6");
        send(1, r, a, 0);
        @(negedge clk);
        exp_msg(3, o, a, 0, "R7");
        resp(o, a, d2);
        wait_idle();
        exp_msg(0, r, a, d2, "R7");
        send(2, o, a, 16'hdead);
        wait_idle();
        exp_none("R9");
        send(0, o, a, 0);
        @(negedge clk);
        exp_msg(2, r, a, 0, "R7");
        resp(r, a, d3);
        wait_idle();
        exp_msg(0, o, a, d3, "R6");
        exp_mem[a] = d3;
        send(2, r, a, 16'hbeef);
        wait_idle();
        exp_none("R9");
        send(1, o, a, 0);
        wait_idle();
        exp_msg(1, r, a, 0, "R6");
        exp_msg(0, o, a, exp_mem[a], "R9");
        send(2, o, a, d4);
        wait_idle();
        exp_none("R8");
        exp_mem[a] = d4;
      end
    end

    // final read of every block: uncached, memory holds the last write-back
    for (int a = 0; a < NB; a++) begin
      send(0, a % NN, a, 0);
      wait_idle();
      exp_msg(0, a % NN, a, exp_mem[a], "R8");
    end
    summary();
    $finish;
  end
endmodule